// File: doc/BRIEF.md
# Polyphase power and current-squared accumulator

This block forms the per-frame energy terms of a three-phase metering datapath. Each multiplexer frame delivers one signed voltage and one signed current sample for each of phases A, B and C. A three-bit wiring-mode code picks how up to three element products are built, some of them from half of a current difference. The code also picks which current, or current difference, feeds each of three current-squared sums. The products and squares are added into signed 48-bit accumulators.

Software loads the wiring mode and the interval length (a count of frames) while the engine is idle, then pulses start. The engine stays busy for exactly that many valid frames. On the last frame it latches the element totals, their grand total and the three squared sums into output registers, pulses done for one cycle and returns to idle. The next interval starts from cleared accumulators.

Top module: `pwr_accum_top`

## Requirements
- R1: After reset, busy and done are low and every accumulator output reads zero.
- R2: A configuration write (cfg_we with cfg_mode and cfg_frames) is taken only while busy is low; a write made while busy changes neither the mode nor the interval length of the running interval.
- R3: A start pulse while idle with a non-zero interval length raises busy on the next cycle; start with interval length zero, or start while busy, is ignored. Busy falls in the same cycle that done is high, and done lasts one cycle.
- R4: Done rises in the cycle after the N-th smp_valid strobe taken while busy, N being the configured frame count (up to 2^PER_W-1). Strobes while idle change neither the accumulators nor the outputs, and outputs hold their values between done pulses.
- R5: Mode 0: pwr0 = sum of VA·IA and isq0 = sum of IA²; pwr1, pwr2, isq1 and isq2 read zero.
- R6: Mode 1: pwr0 = sum of (VA·(IA−IB))>>>1, isq0 = sum of (IA−IB)², isq1 = sum of IB²; pwr1, pwr2 and isq2 read zero.
- R7: Mode 2: pwr0 = sum of VA·IA, pwr1 = sum of VB·IB, isq0 = sum of IA², isq1 = sum of IB²; pwr2 and isq2 read zero.
- R8: Mode 3: pwr0 = sum of (VA·(IA−IB))>>>1, pwr2 = sum of VC·IC, pwr1 reads zero; isq0, isq1, isq2 are the sums of (IA−IB)², IB², IC².
- R9: Mode 4: pwr0 = sum of (VA·(IA−IB))>>>1, pwr1 = sum of (VB·(IC−IB))>>>1, pwr2 reads zero; isq0, isq1, isq2 are the sums of (IA−IB)², (IC−IB)², IC².
- R10: Mode 5, and codes 6 and 7 which behave as 5: pwr0, pwr1, pwr2 are the sums of VA·IA, VB·IB, VC·IC and isq0, isq1, isq2 the sums of IA², IB², IC².
- R11: Each half-difference term is the full product shifted right by one arithmetically per frame, before it is accumulated, so an odd negative product rounds toward minus infinity (for example −3 gives −2).
- R12: pwr_tot equals pwr0 + pwr1 + pwr2 of the same interval, and each interval starts from zero accumulators, so no term of an earlier interval reaches later results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Wiring-mode code |
| cfg_frames | input | PER_W | Frames per interval |
| start | input | 1 | Start one interval |
| busy | output | 1 | Interval in progress |
| smp_valid | input | 1 | Sample set valid this cycle |
| va | input | SAMP_W | Phase A voltage, signed |
| ia | input | SAMP_W | Phase A current, signed |
| vb | input | SAMP_W | Phase B voltage, signed |
| ib | input | SAMP_W | Phase B current, signed |
| vc | input | SAMP_W | Phase C voltage, signed |
| ic | input | SAMP_W | Phase C current, signed |
| done | output | 1 | One-cycle interval-complete pulse |
| pwr0 | output | ACC_W | Element 0 power sum, signed |
| pwr1 | output | ACC_W | Element 1 power sum, signed |
| pwr2 | output | ACC_W | Element 2 power sum, signed |
| pwr_tot | output | ACC_W | Sum of the three element sums, signed |
| isq0 | output | ACC_W | Current-squared sum 0 |
| isq1 | output | ACC_W | Current-squared sum 1 |
| isq2 | output | ACC_W | Current-squared sum 2 |

## Verification
The bench keeps the default 16-bit samples and 48-bit accumulators, so full-scale inputs of both signs, including −32768 against 32767 in the half-difference modes, exercise the widest differences and products exactly. It narrows the frame counter to 8 bits, which puts the largest legal interval of 255 frames within a short run and lets the exact end-of-interval frame be checked at that limit. A 64-bit model in the bench gives the expected sums for every wiring code, the two alias codes among them.

// File: rtl/pa_pkg.sv
package pa_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_A    = 3'd1,
    SRC_B    = 3'd2,
    SRC_C    = 3'd3,
    SRC_AB   = 3'd4,
    SRC_CB   = 3'd5
  } isrc_e;

  typedef struct packed {
    isrc_e p0, p1, p2;
    logic  h0, h1, h2;
    isrc_e q0, q1, q2;
  } route_t;

  function automatic route_t decode_mode(input logic [2:0] m);
    route_t r;
    r.p0 = SRC_NONE; r.p1 = SRC_NONE; r.p2 = SRC_NONE;
    r.h0 = 1'b0;     r.h1 = 1'b0;     r.h2 = 1'b0;
    r.q0 = SRC_NONE; r.q1 = SRC_NONE; r.q2 = SRC_NONE;
    case (m)
      3'd0: begin
        r.p0 = SRC_A;  r.q0 = SRC_A;
      end
      3'd1: begin
        r.p0 = SRC_AB; r.h0 = 1'b1;
        r.q0 = SRC_AB; r.q1 = SRC_B;
      end
      3'd2: begin
        r.p0 = SRC_A;  r.p1 = SRC_B;
        r.q0 = SRC_A;  r.q1 = SRC_B;
      end
      3'd3: begin
        r.p0 = SRC_AB; r.h0 = 1'b1; r.p2 = SRC_C;
        r.q0 = SRC_AB; r.q1 = SRC_B; r.q2 = SRC_C;
      end
      3'd4: begin
        r.p0 = SRC_AB; r.h0 = 1'b1;
        r.p1 = SRC_CB; r.h1 = 1'b1;
        r.q0 = SRC_AB; r.q1 = SRC_CB; r.q2 = SRC_C;
      end
      default: begin
        r.p0 = SRC_A;  r.p1 = SRC_B;  r.p2 = SRC_C;
        r.q0 = SRC_A;  r.q1 = SRC_B;  r.q2 = SRC_C;
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pa_cur_mux.sv
module pa_cur_mux import pa_pkg::*; #(
  parameter int SAMP_W = 16,
  localparam int DW = SAMP_W + 1
) (
  input  isrc_e                    src,
  input  logic signed [SAMP_W-1:0] ia,
  input  logic signed [SAMP_W-1:0] ib,
  input  logic signed [SAMP_W-1:0] ic,
  output logic signed [DW-1:0]     cur
);
  logic signed [DW-1:0] xa, xb, xc;
  assign xa = {ia[SAMP_W-1], ia};
  assign xb = {ib[SAMP_W-1], ib};
  assign xc = {ic[SAMP_W-1], ic};

  always_comb begin
    case (src)
      SRC_A:   cur = xa;
      SRC_B:   cur = xb;
      SRC_C:   cur = xc;
      SRC_AB:  cur = xa - xb;
      SRC_CB:  cur = xc - xb;
      default: cur = '0;
    endcase
  end
endmodule

// File: rtl/pa_mul.sv
module pa_mul #(
  parameter int DW    = 17,
  parameter int ACC_W = 48,
  localparam int PW   = 2 * DW
) (
  input  logic signed [DW-1:0]    a,
  input  logic signed [DW-1:0]    b,
  input  logic                    half,
  output logic signed [ACC_W-1:0] term
);
  logic signed [PW-1:0] ax, bx, prod, scaled;
  assign ax     = {{DW{a[DW-1]}}, a};
  assign bx     = {{DW{b[DW-1]}}, b};
  assign prod   = ax * bx;
  assign scaled = half ? (prod >>> 1) : prod;
  assign term   = {{(ACC_W-PW){scaled[PW-1]}}, scaled};
endmodule

// File: rtl/pa_accum.sv
module pa_accum #(
  parameter int ACC_W = 48
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    take,
  input  logic                    fresh,
  input  logic signed [ACC_W-1:0] term,
  output logic signed [ACC_W-1:0] acc_nxt
);
  logic signed [ACC_W-1:0] acc_q;

  assign acc_nxt = fresh ? term : acc_q + term;

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (take) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/pa_ctrl.sv
module pa_ctrl #(
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_mode,
  input  logic [PER_W-1:0] cfg_frames,
  input  logic             start,
  input  logic             smp_valid,
  output logic             busy,
  output logic [2:0]       mode_q,
  output logic             take,
  output logic             last,
  output logic             fresh
);
  logic [PER_W-1:0] per_q, cnt_q;

  assign take = busy & smp_valid;
  assign last = take & (cnt_q == per_q - PER_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      mode_q <= '0;
      per_q  <= '0;
      cnt_q  <= '0;
      fresh  <= 1'b1;
    end else begin
      if (!busy && cfg_we) begin
        mode_q <= cfg_mode;
        per_q  <= cfg_frames;
      end
      if (!busy && start && per_q != '0) begin
        busy  <= 1'b1;
        cnt_q <= '0;
      end else if (take) begin
        fresh <= last;
        if (last) begin
          busy  <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + PER_W'(1);
        end
      end
    end
  end

  // R4: the frame counter never reaches the interval length
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> cnt_q < per_q);

  // R2: configuration is frozen for the whole interval
  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(mode_q) && $stable(per_q)));

  // R3: a zero-length start leaves the engine idle
  assert_zero_start_R3: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && per_q == '0 && !cfg_we) |=> !busy);
endmodule

// File: rtl/pwr_accum_top.sv
module pwr_accum_top import pa_pkg::*; #(
  parameter int SAMP_W = 16,
  parameter int ACC_W  = 48,
  parameter int PER_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [2:0]              cfg_mode,
  input  logic [PER_W-1:0]        cfg_frames,
  input  logic                    start,
  output logic                    busy,
  input  logic                    smp_valid,
  input  logic signed [SAMP_W-1:0] va,
  input  logic signed [SAMP_W-1:0] ia,
  input  logic signed [SAMP_W-1:0] vb,
  input  logic signed [SAMP_W-1:0] ib,
  input  logic signed [SAMP_W-1:0] vc,
  input  logic signed [SAMP_W-1:0] ic,
  output logic                    done,
  output logic signed [ACC_W-1:0] pwr0,
  output logic signed [ACC_W-1:0] pwr1,
  output logic signed [ACC_W-1:0] pwr2,
  output logic signed [ACC_W-1:0] pwr_tot,
  output logic signed [ACC_W-1:0] isq0,
  output logic signed [ACC_W-1:0] isq1,
  output logic signed [ACC_W-1:0] isq2
);
  localparam int NEL = 3;
  localparam int DW  = SAMP_W + 1;

  logic       take, last, fresh;
  logic [2:0] mode_q;
  route_t     rt;

  pa_ctrl #(.PER_W(PER_W)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_frames(cfg_frames), .start(start), .smp_valid(smp_valid),
    .busy(busy), .mode_q(mode_q), .take(take), .last(last), .fresh(fresh)
  );

  assign rt = decode_mode(mode_q);

  isrc_e                    psrc [NEL];
  isrc_e                    qsrc [NEL];
  logic                     phalf[NEL];
  logic signed [SAMP_W-1:0] volt [NEL];
  logic signed [ACC_W-1:0]  pnxt [NEL];
  logic signed [ACC_W-1:0]  qnxt [NEL];

  assign psrc[0] = rt.p0;  assign psrc[1] = rt.p1;  assign psrc[2] = rt.p2;
  assign qsrc[0] = rt.q0;  assign qsrc[1] = rt.q1;  assign qsrc[2] = rt.q2;
  assign phalf[0] = rt.h0; assign phalf[1] = rt.h1; assign phalf[2] = rt.h2;
  assign volt[0] = va;     assign volt[1] = vb;     assign volt[2] = vc;

  for (genvar k = 0; k < NEL; k++) begin : g_el
    logic signed [DW-1:0]    pcur, qcur, vx;
    logic signed [ACC_W-1:0] pterm, qterm;

    assign vx = {volt[k][SAMP_W-1], volt[k]};

    pa_cur_mux #(.SAMP_W(SAMP_W)) u_pmux (
      .src(psrc[k]), .ia(ia), .ib(ib), .ic(ic), .cur(pcur));
    pa_cur_mux #(.SAMP_W(SAMP_W)) u_qmux (
      .src(qsrc[k]), .ia(ia), .ib(ib), .ic(ic), .cur(qcur));

    pa_mul #(.DW(DW), .ACC_W(ACC_W)) u_pmul (
      .a(vx), .b(pcur), .half(phalf[k]), .term(pterm));
    pa_mul #(.DW(DW), .ACC_W(ACC_W)) u_qmul (
      .a(qcur), .b(qcur), .half(1'b0), .term(qterm));

    pa_accum #(.ACC_W(ACC_W)) u_pacc (
      .clk(clk), .rst(rst), .take(take), .fresh(fresh),
      .term(pterm), .acc_nxt(pnxt[k]));
    pa_accum #(.ACC_W(ACC_W)) u_qacc (
      .clk(clk), .rst(rst), .take(take), .fresh(fresh),
      .term(qterm), .acc_nxt(qnxt[k]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      pwr0    <= '0; pwr1 <= '0; pwr2 <= '0; pwr_tot <= '0;
      isq0    <= '0; isq1 <= '0; isq2 <= '0;
    end else begin
      done <= last;
      if (last) begin
        pwr0    <= pnxt[0];
        pwr1    <= pnxt[1];
        pwr2    <= pnxt[2];
        pwr_tot <= pnxt[0] + pnxt[1] + pnxt[2];
        isq0    <= qnxt[0];
        isq1    <= qnxt[1];
        isq2    <= qnxt[2];
      end
    end
  end

  // R3: done is a single-cycle pulse
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3: busy has dropped by the time done is seen
  assert_busy_drop_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R4: results only move on a done cycle
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(pwr_tot) && $stable(pwr0) && $stable(isq0)));

  // R5: single-element mode leaves the other lanes at zero
  assert_unused_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == 3'd0) |-> (pwr1 == '0 && pwr2 == '0 && isq1 == '0 && isq2 == '0));

  // R8: mode 3 never fills element 1
  assert_mode3_gap_R8: assert property (@(posedge clk) disable iff (rst)
    (done && mode_q == 3'd3) |-> (pwr1 == '0));
endmodule

// File: tb/pwr_accum_top_test.sv
module pwr_accum_top_test;
  localparam int SW = 16;
  localparam int AW = 48;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_mode = '0;
  logic [PW-1:0] cfg_frames = '0;
  logic start = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [SW-1:0] va = '0, ia = '0, vb = '0, ib = '0, vc = '0, ic = '0;
  logic busy, done;
  logic signed [AW-1:0] pwr0, pwr1, pwr2, pwr_tot, isq0, isq1, isq2;

  int total = 0;
  int bad   = 0;
  longint ee[3];
  longint qq[3];

  always #10 clk = ~clk;

  pwr_accum_top #(.SAMP_W(SW), .ACC_W(AW), .PER_W(PW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_frames(cfg_frames), .start(start), .busy(busy),
    .smp_valid(smp_valid), .va(va), .ia(ia), .vb(vb), .ib(ib),
    .vc(vc), .ic(ic), .done(done), .pwr0(pwr0), .pwr1(pwr1),
    .pwr2(pwr2), .pwr_tot(pwr_tot), .isq0(isq0), .isq1(isq1), .isq2(isq2)
  );

  // rows: mode, va, ia, vb, ib, vc, ic
  localparam int NV = 9;
  localparam int VT[NV][7] = '{
    '{0,   1000,   -300,      5,     6,      7,     8},  // R5
    '{1,     -3,      4,      3,     9,      2,     1},  // R6 R11
    '{2,   1200,     50,   -800,    70,      9,     9},  // R7
    '{3,    700,    -20,    400,    15,   -900,    33},  // R8
    '{4,  32767, -32768, -32768, 32767,    100,    -5},  // R9
    '{5,  -1500,    222,   1300,  -111,    250,   444},  // R10
    '{6,     17,    -19,     23,    29,    -31,    37},  // R10 alias
    '{7, -32768, -32768,  32767, 32767, -32768, 32767},  // R10 alias
    '{4,      5,      7,     -9,     3,     11,   -13}   // R9 R11
  };

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < 3; k++) begin ee[k] = 0; qq[k] = 0; end
  endtask

  // independent model of the per-frame terms, taken from the requirements
  task automatic add_model(input int m, input longint xva, input longint xia,
                           input longint xvb, input longint xib,
                           input longint xvc, input longint xic);
    int mm = (m > 5) ? 5 : m;
    longint dab = xia - xib;
    longint dcb = xic - xib;
    case (mm)
      0: begin ee[0] += xva * xia; qq[0] += xia * xia; end
      1: begin ee[0] += (xva * dab) >>> 1; qq[0] += dab * dab; qq[1] += xib * xib; end
      2: begin ee[0] += xva * xia; ee[1] += xvb * xib;
               qq[0] += xia * xia; qq[1] += xib * xib; end
      3: begin ee[0] += (xva * dab) >>> 1; ee[2] += xvc * xic;
               qq[0] += dab * dab; qq[1] += xib * xib; qq[2] += xic * xic; end
      4: begin ee[0] += (xva * dab) >>> 1; ee[1] += (xvb * dcb) >>> 1;
               qq[0] += dab * dab; qq[1] += dcb * dcb; qq[2] += xic * xic; end
      default: begin ee[0] += xva * xia; ee[1] += xvb * xib; ee[2] += xvc * xic;
               qq[0] += xia * xia; qq[1] += xib * xib; qq[2] += xic * xic; end
    endcase
  endtask

  task automatic cfg(input int m, input int n);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 3'(m); cfg_frames = PW'(n);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic go();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic smp(input longint xva, input longint xia, input longint xvb,
                     input longint xib, input longint xvc, input longint xic);
    @(negedge clk);
    smp_valid = 1'b1;
    va = SW'(xva); ia = SW'(xia); vb = SW'(xvb);
    ib = SW'(xib); vc = SW'(xvc); ic = SW'(xic);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic check_outs(input string tag);
    check(tag, "pwr0", pwr0, ee[0]);
    check(tag, "pwr1", pwr1, ee[1]);
    check(tag, "pwr2", pwr2, ee[2]);
    check(tag, "pwr_tot", pwr_tot, ee[0] + ee[1] + ee[2]);
    check(tag, "isq0", isq0, qq[0]);
    check(tag, "isq1", isq1, qq[1]);
    check(tag, "isq2", isq2, qq[2]);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "pwr_tot", pwr_tot, 0);
    check("R1", "isq0", isq0, 0);

    // vector table: two frames per interval, second frame with halved currents
    for (int v = 0; v < NV; v++) begin
      string tag;
      int m;
      m = VT[v][0];
      tag = $sformatf("R%0d", 5 + ((m > 5) ? 5 : m));
      clear_model();
      cfg(m, 2);
      go();
      smp(VT[v][1], VT[v][2], VT[v][3], VT[v][4], VT[v][5], VT[v][6]);
      add_model(m, VT[v][1], VT[v][2], VT[v][3], VT[v][4], VT[v][5], VT[v][6]);
      check(tag, "done early", done, 0);
      smp(VT[v][1], VT[v][2] / 2, VT[v][3], VT[v][4] / 2, VT[v][5], VT[v][6] / 2);
      add_model(m, VT[v][1], VT[v][2] / 2, VT[v][3], VT[v][4] / 2, VT[v][5], VT[v][6] / 2);
      check(tag, "done", done, 1);
      check_outs(tag);
    end

    // R11 odd negative product rounds down: -3*1 -> -2 in one frame
    clear_model();
    cfg(1, 1); go();
    smp(-3, 1, 0, 0, 0, 0);
    check("R11", "pwr0", pwr0, -2);

    // R3 start behaviour and done width
    cfg(2, 0); go();
    check("R3", "busy after zero-length start", busy, 0);
    cfg(2, 1); go();
    check("R3", "busy after start", busy, 1);
    smp(10, 20, 30, 40, 0, 0);
    check("R3", "busy at done", busy, 0);
    check("R3", "done", done, 1);
    @(negedge clk);
    check("R3", "done one cycle", done, 0);

    // R4 idle strobes ignored, outputs hold
    clear_model();
    cfg(5, 1);
    smp(999, 999, 999, 999, 999, 999);
    check("R4", "done on idle strobe", done, 0);
    check("R4", "pwr0 held while idle", pwr0, 200);
    go();
    smp(2, 3, 4, 5, 6, 7);
    add_model(5, 2, 3, 4, 5, 6, 7);
    check_outs("R4");

    // R2 configuration write while busy ignored
    clear_model();
    cfg(0, 3); go();
    cfg(5, 1);
    for (int f = 0; f < 3; f++) begin
      smp(100 + f, 7, 50, 60, 70, 80);
      add_model(0, 100 + f, 7, 50, 60, 70, 80);
      if (f < 2) check("R2", "done before third frame", done, 0);
    end
    check("R2", "done after third frame", done, 1);
    check_outs("R2");

    // R12 fresh accumulators on each interval
    clear_model();
    cfg(2, 1); go();
    smp(300, 300, 300, 300, 0, 0);
    go();
    smp(-4, 5, 6, -7, 0, 0);
    add_model(2, -4, 5, 6, -7, 0, 0);
    check_outs("R12");

    // R4 longest interval of 255 frames
    begin
      int early;
      early = 0;
      clear_model();
      cfg(3, 255); go();
      for (int f = 0; f < 255; f++) begin
        smp(-200 + f, f - 100, 3 * f, 17 - f, 1000 - f, f);
        add_model(3, -200 + f, f - 100, 3 * f, 17 - f, 1000 - f, f);
        if (f < 254 && done) early++;
      end
      check("R4", "early done count", early, 0);
      check("R4", "done at frame 255", done, 1);
      check_outs("R4");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule